// File: doc/BRIEF.md
# Dual-Descriptor Byte DMA Engine

This block moves a byte stream from memory to a peripheral under the control of two transfer descriptors, A and B. Each descriptor names a start address, a byte count and whether it closes the buffer. The engine works through the descriptor whose turn it is, one byte at a time. It fetches each byte over a request/valid memory port and hands it to the peripheral over a valid/ready port. When a descriptor is used up, the engine drops its valid flag, pulses that descriptor's own interrupt line and passes the turn to the other descriptor. Software can therefore refill one descriptor while the engine drains the other.

Software reaches the engine through a small register port with four word addresses: control/status, descriptor A, descriptor B and a diagnostic word. The diagnostic word shows whether a descriptor is part way through, which one holds the turn, and how many bytes it still owes. This lets software work out the residue after it stops the engine. A descriptor whose bytes would run past the end of a page is refused when it is written.

Top module: `dual_ctx_dma`

## Requirements
- R1: After rst_n low, or after a control write with bit 0 set (soft reset), the following all read zero: the status word, the diagnostic word, page_err, mem_req, out_valid, both interrupts and both descriptors. The next turn belongs to A.
- R2: Register addresses are 0 control/status, 1 descriptor A, 2 descriptor B and 3 diagnostic. A descriptor word holds the start address in bits [ADDR_W-1:0], the byte count minus one in bits [ADDR_W+PAGE_LOG2-1:ADDR_W] and the closing flag in bit ADDR_W+PAGE_LOG2. Writing a descriptor whose valid flag is clear stores the word and sets that flag: status bit 3 for A, bit 4 for B. The stored word reads back unchanged.
- R3: A write to a descriptor whose valid flag is set has no effect.
- R4: If the start offset within a page of 2^PAGE_LOG2 bytes plus the count minus one exceeds the page size minus one, the write is refused. Status bit 5 and page_err then become set and stay set until a reset. A descriptor that ends exactly on the last byte of a page is accepted.
- R5: While enabled (status bit 2), the engine moves the bytes at start, start+1, ... in order. Each byte is read on the memory port and shown on out_data. The engine moves on only after a cycle with out_valid and out_ready both high. mem_addr holds while mem_req waits, and out_data holds while out_valid waits.
- R6: Descriptors take turns A, B, A, ... When the last byte of a descriptor is accepted, its valid flag clears at that edge, and its own interrupt pulses high for exactly the next cycle.
- R7: When a descriptor that carries the closing flag finishes, the enable bit clears and the other descriptor is not fetched, even if it is valid.
- R8: While enabled, if the descriptor whose turn it is is not valid, the engine issues no read, moves no byte and raises no interrupt.
- R9: Clearing the enable bit stops the engine at a byte boundary. No read and no byte offer follow, and the valid flags stay as they were. The diagnostic word keeps bit 0 = descriptor in progress, bit 1 = descriptor holding the turn (0 A, 1 B) and bits [PAGE_LOG2+1:2] = bytes still owed minus one. Setting enable again resumes from the next unsent byte.
- R10: With the direction bit (status bit 1) set to 1, the engine starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | ADDR_W+PAGE_LOG2+1 | Register write data |
| reg_rdata | output | ADDR_W+PAGE_LOG2+1 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_valid | input | 1 | Memory returns mem_data; meaningful only while mem_req is high |
| mem_data | input | 8 | Memory read byte |
| out_valid | output | 1 | Byte offered to the peripheral |
| out_data | output | 8 | Byte to the peripheral |
| out_ready | input | 1 | Peripheral accepts the byte |
| irq_a | output | 1 | One-cycle pulse when descriptor A finishes |
| irq_b | output | 1 | One-cycle pulse when descriptor B finishes |
| page_err | output | 1 | Sticky flag for a refused page-crossing descriptor |

## Verification
The bench builds the engine with ADDR_W = 16 and PAGE_LOG2 = 5, which gives 32-byte pages. With pages that small, a descriptor that fills a whole page, one that ends exactly on a page's last byte and one that spills over by a byte can all be reached in a few dozen cycles. The same setting keeps the diagnostic count narrow enough to check exactly after a stop part way through a buffer. A behavioural model holds a queue of expected addresses and bytes, and it checks the memory address, every accepted byte and the cycle of each interrupt pulse. Memory latency and peripheral readiness alternate between an always-ready pattern and a pseudo-random one.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_SEND} mv_state_e;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_CTXA = 2'd1;
  localparam logic [1:0] RA_CTXB = 2'd2;
  localparam logic [1:0] RA_DIAG = 2'd3;

  localparam int CB_RESET = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_EN    = 2;
  localparam int CB_VA    = 3;
  localparam int CB_VB    = 4;
  localparam int CB_ERR   = 5;
endpackage

// File: rtl/dma2_ctx_bank.sv
module dma2_ctx_bank #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  localparam int REG_W = ADDR_W + CNT_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [1:0]            wr_en,
  input  logic [REG_W-1:0]      wdata,
  input  logic [1:0]            done,
  output logic [1:0][REG_W-1:0] ctx_q,
  output logic [1:0]            valid_q,
  output logic                  err_q
);
  // End offset of the segment within its page; the carry out means a crossing.
  function automatic logic page_cross(input logic [REG_W-1:0] w);
    logic [CNT_W:0] tail;
    tail = {1'b0, w[CNT_W-1:0]} + {1'b0, w[ADDR_W+CNT_W-1:ADDR_W]};
    return tail[CNT_W];
  endfunction

  logic bad_w;
  assign bad_w = page_cross(wdata);

  for (genvar i = 0; i < 2; i++) begin : g_ctx
    logic [REG_W-1:0] word_r;
    logic             vld_r;
    logic             take;

    assign take       = wr_en[i] && !vld_r && !bad_w;
    assign ctx_q[i]   = word_r;
    assign valid_q[i] = vld_r;

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        word_r <= '0;
        vld_r  <= 1'b0;
      end else if (take) begin
        word_r <= wdata;
        vld_r  <= 1'b1;
      end else if (done[i]) begin
        vld_r  <= 1'b0;
      end
    end

    // R2: an accepted write stores the word and marks it valid
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[i] && !vld_r && !bad_w && !clr) |=> (vld_r && word_r == $past(wdata)));
    // R3: a write to a pending descriptor changes nothing
    p_busy_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[i] && vld_r && !clr) |=> $stable(word_r));
    // R4: a page-crossing descriptor is refused and flagged
    p_cross_rejected_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[i] && !vld_r && bad_w && !clr) |=> (!vld_r && err_q));
    // R6: completion drops the valid flag
    p_done_clears_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done[i] && !clr) |=> !vld_r);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) err_q <= 1'b0;
    else if (|(wr_en & ~valid_q) && bad_w) err_q <= 1'b1;
  end
endmodule

// File: rtl/dma2_regs.sv
module dma2_regs
  import dma2_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  localparam int REG_W = ADDR_W + CNT_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [2:0]            ctl_bits,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  last_done,
  input  logic [1:0]            ctx_valid,
  input  logic                  page_err,
  input  logic [1:0][REG_W-1:0] ctx_word,
  input  logic                  busy,
  input  logic                  cur,
  input  logic [CNT_W-1:0]      cnt,
  output logic                  en,
  output logic                  dir,
  output logic                  clr,
  output logic [1:0]            ctx_wr
);
  logic ctrl_wr;
  logic [REG_W-1:0] status_w, diag_w;

  assign clr       = reg_wr && (reg_addr == RA_CTRL) && ctl_bits[CB_RESET];
  assign ctrl_wr   = reg_wr && (reg_addr == RA_CTRL) && !ctl_bits[CB_RESET];
  assign ctx_wr[0] = reg_wr && (reg_addr == RA_CTXA);
  assign ctx_wr[1] = reg_wr && (reg_addr == RA_CTXB);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      en  <= 1'b0;
      dir <= 1'b0;
    end else if (ctrl_wr) begin
      en  <= ctl_bits[CB_EN];
      dir <= ctl_bits[CB_DIR];
    end else if (last_done) begin
      en  <= 1'b0;
    end
  end

  always_comb begin
    status_w         = '0;
    status_w[CB_DIR] = dir;
    status_w[CB_EN]  = en;
    status_w[CB_VA]  = ctx_valid[0];
    status_w[CB_VB]  = ctx_valid[1];
    status_w[CB_ERR] = page_err;
    diag_w           = '0;
    diag_w[0]        = busy;
    diag_w[1]        = cur;
    diag_w[CNT_W+1:2] = cnt;
    unique case (reg_addr)
      RA_CTRL: reg_rdata = status_w;
      RA_CTXA: reg_rdata = ctx_word[0];
      RA_CTXB: reg_rdata = ctx_word[1];
      default: reg_rdata = diag_w;
    endcase
  end

  // R7: a finished closing descriptor drops enable
  p_last_clears_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_done && !reg_wr) |=> !en);
  // R1: soft reset returns the control bits to zero
  p_soft_reset_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!en && !dir));
endmodule

// File: rtl/dma2_mover.sv
module dma2_mover
  import dma2_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  localparam int REG_W = ADDR_W + CNT_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  en,
  input  logic                  dir,
  input  logic [1:0]            ctx_valid,
  input  logic [1:0][REG_W-1:0] ctx_word,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic                  mem_valid,
  input  logic [7:0]            mem_data,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  input  logic                  out_ready,
  output logic [1:0]            done,
  output logic                  done_last,
  output logic [1:0]            irq,
  output logic                  busy,
  output logic                  cur,
  output logic [CNT_W-1:0]      cnt
);
  function automatic logic [ADDR_W-1:0] f_base(input logic [REG_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction
  function automatic logic [CNT_W-1:0] f_len(input logic [REG_W-1:0] w);
    return w[ADDR_W+CNT_W-1:ADDR_W];
  endfunction
  function automatic logic f_last(input logic [REG_W-1:0] w);
    return w[ADDR_W+CNT_W];
  endfunction

  mv_state_e         st_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_q, cur_q, loaded_q;
  logic [7:0]        obuf_q;
  logic [1:0]        irq_q;
  logic [REG_W-1:0]  cw;
  logic              start, fin;

  assign cw        = ctx_word[cur_q];
  assign start     = en && !dir && ctx_valid[cur_q];
  assign mem_req   = (st_q == ST_READ) && en;
  assign mem_addr  = ptr_q;
  assign out_valid = (st_q == ST_SEND) && en;
  assign out_data  = obuf_q;
  assign fin       = out_valid && out_ready && (cnt_q == '0);
  assign done      = fin ? (cur_q ? 2'b10 : 2'b01) : 2'b00;
  assign done_last = fin && last_q;
  assign irq       = irq_q;
  assign busy      = loaded_q;
  assign cur       = cur_q;
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st_q     <= ST_IDLE;
      ptr_q    <= '0;
      cnt_q    <= '0;
      last_q   <= 1'b0;
      cur_q    <= 1'b0;
      loaded_q <= 1'b0;
      obuf_q   <= '0;
      irq_q    <= '0;
    end else begin
      irq_q <= done;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (!loaded_q) begin
              ptr_q    <= f_base(cw);
              cnt_q    <= f_len(cw);
              last_q   <= f_last(cw);
              loaded_q <= 1'b1;
            end
            st_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (!en) st_q <= ST_IDLE;
          else if (mem_valid) begin
            obuf_q <= mem_data;
            st_q   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (!en) st_q <= ST_IDLE;
          else if (out_ready) begin
            if (cnt_q == '0) begin
              loaded_q <= 1'b0;
              cur_q    <= ~cur_q;
              st_q     <= ST_IDLE;
            end else begin
              ptr_q <= ptr_q + 1'b1;
              cnt_q <= cnt_q - 1'b1;
              st_q  <= ST_READ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5: request and offer hold their payload while waiting
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (!mem_req || $stable(mem_addr)));
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!out_valid || $stable(out_data)));
  // R6: at most one interrupt at a time
  p_irq_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q));
  // R8: no read when the descriptor in turn is absent
  p_idle_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !ctx_valid[cur_q]) |=> !mem_req);
  // R9: position and count freeze while disabled
  p_hold_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(cnt_q) && $stable(ptr_q)));
  // R10: reverse direction starts nothing
  p_dir_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && st_q == ST_IDLE) |=> !mem_req);
  // R1: soft reset empties the mover
  p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!mem_req && !out_valid && !loaded_q && irq_q == 2'b00));
endmodule

// File: rtl/dual_ctx_dma.sv
module dual_ctx_dma #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 12,
  localparam int REG_W    = ADDR_W + PAGE_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [7:0]        mem_data,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              irq_a,
  output logic              irq_b,
  output logic              page_err
);
  logic                  en, dir, clr, done_last, busy, cur, err;
  logic [1:0]            ctx_wr, done, valid, irq;
  logic [1:0][REG_W-1:0] ctx_word;
  logic [PAGE_LOG2-1:0]  cnt;

  dma2_regs #(.ADDR_W(ADDR_W), .CNT_W(PAGE_LOG2)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr,
    .ctl_bits (reg_wdata[2:0]),
    .reg_rdata,
    .last_done (done_last),
    .ctx_valid (valid),
    .page_err  (err),
    .ctx_word,
    .busy, .cur, .cnt,
    .en, .dir, .clr,
    .ctx_wr
  );

  dma2_ctx_bank #(.ADDR_W(ADDR_W), .CNT_W(PAGE_LOG2)) u_bank (
    .clk, .rst_n, .clr,
    .wr_en   (ctx_wr),
    .wdata   (reg_wdata),
    .done,
    .ctx_q   (ctx_word),
    .valid_q (valid),
    .err_q   (err)
  );

  dma2_mover #(.ADDR_W(ADDR_W), .CNT_W(PAGE_LOG2)) u_mover (
    .clk, .rst_n, .clr, .en, .dir,
    .ctx_valid (valid),
    .ctx_word,
    .mem_req, .mem_addr, .mem_valid, .mem_data,
    .out_valid, .out_data, .out_ready,
    .done, .done_last, .irq,
    .busy, .cur, .cnt
  );

  assign irq_a    = irq[0];
  assign irq_b    = irq[1];
  assign page_err = err;

  // R6: an interrupt pulse finds its descriptor already released
  p_irq_a_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> !valid[0]);
  p_irq_b_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> !valid[1]);
endmodule

// File: tb/dual_ctx_dma_tb.sv
`timescale 1ns/1ps
module dual_ctx_dma_tb;
  localparam int AW = 16;
  localparam int PL = 5;
  localparam int RW = AW + PL + 1;
  localparam int S_DIR = 2, S_EN = 4, S_VA = 8, S_VB = 16, S_ERR = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          mem_req, mem_valid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data = 8'h00, out_data;
  logic          out_valid, out_ready = 1'b0;
  logic          irq_a, irq_b, page_err;

  dual_ctx_dma #(.ADDR_W(AW), .PAGE_LOG2(PL)) u_dut (.*);

  always #10 clk = ~clk;

  int n_checks = 0, n_err = 0;
  int cycles = 0, sent = 0, req_seen = 0, pend_irq = -1;
  bit fast = 1'b1, run = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int q_addr[$];
  int q_ctx[$];
  bit q_end[$];

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 13) + (a >> 8) + 5);
  endfunction

  function automatic logic [RW-1:0] mk_ctx(input int base, input int lm1, input bit last);
    return {last, PL'(lm1), AW'(base)};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_ctx(input int base, input int lm1, input int ctx);
    for (int k = 0; k <= lm1; k++) begin
      q_addr.push_back(base + k);
      q_ctx.push_back(ctx);
      q_end.push_back(k == lm1);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [RW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_empty();
    int guard = 0;
    while (q_addr.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
  endtask

  // Behavioural reference, evaluated every cycle between edges
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_err++;
      $display("FAIL R5 watchdog: actual %0d cycles expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
    if (run) begin
      // R6: interrupt exactly one cycle after the final byte of a descriptor
      if (irq_a || irq_b || pend_irq >= 0)
        chk("R6 irq", {irq_b, irq_a}, pend_irq < 0 ? 0 : (pend_irq == 0 ? 1 : 2));
      pend_irq = -1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = fast ? 1'b1 : (lfsr[0] | lfsr[3]);
      if (mem_req) begin
        req_seen++;
        mem_valid = fast ? 1'b1 : lfsr[1];
        mem_data = mem_byte(int'(mem_addr));
        if (mem_valid) begin
          if (q_addr.size() == 0) chk("R8 unexpected read", 1, 0);
          else chk("R5 address", mem_addr, AW'(q_addr[0]));
        end
      end else begin
        mem_valid = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (q_addr.size() == 0) chk("R7 unexpected byte", 1, 0);
        else begin
          chk("R5 data", out_data, mem_byte(q_addr[0]));
          if (q_end[0]) pend_irq = q_ctx[0];
          void'(q_addr.pop_front());
          void'(q_ctx.pop_front());
          void'(q_end.pop_front());
          sent++;
        end
      end
    end
  end

  initial begin
    logic [RW-1:0] rd;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 mem_req", mem_req, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 irq", {irq_b, irq_a}, 0);
    reg_read(2'd0, rd); chk("R1 status", rd, 0);
    reg_read(2'd3, rd); chk("R1 diag", rd, 0);
    run = 1'b1;

    // R2 R6 R7: A then B (B closes the buffer)
    fast = 1'b1;
    reg_write(2'd1, mk_ctx('h0100, 3, 0));
    reg_read(2'd0, rd); chk("R2 valid A", rd, S_VA);
    reg_read(2'd1, rd); chk("R2 readback A", rd, mk_ctx('h0100, 3, 0));
    reg_write(2'd2, mk_ctx('h0205, 2, 1));
    push_ctx('h0100, 3, 0);
    push_ctx('h0205, 2, 1);
    reg_write(2'd0, S_EN);
    wait_empty();
    reg_read(2'd0, rd); chk("R6 both released, R7 enable off", rd, 0);

    // R7: closing A leaves valid B unfetched
    fast = 1'b0;
    reg_write(2'd1, mk_ctx('h0400, 1, 1));
    reg_write(2'd2, mk_ctx('h0500, 0, 0));
    push_ctx('h0400, 1, 0);
    reg_write(2'd0, S_EN);
    wait_empty();
    repeat (10) @(negedge clk);
    reg_read(2'd0, rd); chk("R7 B left pending", rd, S_VB);
    push_ctx('h0500, 0, 1);
    reg_write(2'd0, S_EN);
    wait_empty();
    reg_read(2'd0, rd); chk("R6 B done, enable kept", rd, S_EN);
    // R8: enabled with nothing valid
    req_seen = 0;
    repeat (40) @(negedge clk);
    chk("R8 no request", req_seen, 0);

    // R4 R3: page checks (32-byte pages)
    reg_write(2'd0, 0);
    reg_write(2'd1, mk_ctx('h003E, 2, 0));
    reg_read(2'd0, rd); chk("R4 crossing refused", rd, S_ERR);
    chk("R4 page_err", page_err, 1);
    reg_write(2'd1, mk_ctx('h003E, 1, 0));
    reg_read(2'd0, rd); chk("R4 exact fit accepted", rd, S_ERR | S_VA);
    reg_write(2'd2, mk_ctx('h0060, 31, 0));
    reg_read(2'd0, rd); chk("R4 full page accepted", rd, S_ERR | S_VA | S_VB);
    reg_write(2'd1, mk_ctx('h0777, 0, 1));
    reg_read(2'd1, rd); chk("R3 write ignored", rd, mk_ctx('h003E, 1, 0));
    push_ctx('h003E, 1, 0);
    push_ctx('h0060, 31, 1);
    reg_write(2'd0, S_EN);
    wait_empty();
    reg_read(2'd0, rd); chk("R5 run drained", rd, S_ERR | S_EN);

    // R1 soft reset, R9 stop and resume
    reg_write(2'd0, 1);
    reg_read(2'd0, rd); chk("R1 soft status", rd, 0);
    reg_read(2'd3, rd); chk("R1 soft diag", rd, 0);
    chk("R1 soft page_err", page_err, 0);
    reg_write(2'd1, mk_ctx('h0300, 15, 1));
    push_ctx('h0300, 15, 0);
    sent = 0;
    reg_write(2'd0, S_EN);
    while (sent < 5) @(negedge clk);
    reg_write(2'd0, 0);
    repeat (3) @(negedge clk);
    req_seen = 0;
    repeat (8) @(negedge clk);
    chk("R9 no request after stop", req_seen, 0);
    n = sent;
    reg_read(2'd3, rd); chk("R9 diag residue", rd, ((15 - n) << 2) | 1);
    reg_read(2'd0, rd); chk("R9 valid kept", rd, S_VA);
    chk("R9 bytes left", q_addr.size(), 16 - n);
    reg_write(2'd0, S_EN);
    wait_empty();
    reg_read(2'd0, rd); chk("R9 resumed to end", rd, 0);

    // R10: reverse direction blocks the start
    reg_write(2'd2, mk_ctx('h0010, 0, 0));
    push_ctx('h0010, 0, 1);
    reg_write(2'd0, S_DIR | S_EN);
    req_seen = 0;
    repeat (30) @(negedge clk);
    chk("R10 no request", req_seen, 0);
    reg_read(2'd0, rd); chk("R10 status", rd, S_VB | S_EN | S_DIR);
    reg_write(2'd0, S_EN);
    wait_empty();
    reg_read(2'd0, rd); chk("R10 forward runs", rd, S_EN);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule